// File: doc/BRIEF.md
# In-Place Exchange Sorter

The block keeps a small set of unsigned words in an internal single-port memory and reorders them in place into ascending order. The host works in two phases. While the run input is low the block is in load mode: the host stores words by address with a write strobe and fetches them back with a read strobe. Raising the run input starts a sort. A controller then steps an outer index and an inner index across the memory, compares the word at the outer index (held in an operand register) with the word at the inner index, and exchanges the two words whenever the first is strictly greater.

An exchange takes two memory writes, first the outer position and then the inner one. After the exchange the operand register is refilled from memory. When every pair has been visited the block raises its done flag and holds it for as long as run stays high. The host then lowers run to return to load mode and reads the sorted words out by address.

Word count and word width are parameters, with defaults of 4 words of 8 bits. The address width is derived from the word count.

Top module: `xsort_engine`

## Requirements
- R1: While rst is high and in the first cycle after it, done_out is 0 and data_out is 0.
- R2: In load mode, wr_in stores data_in at addr_in. rd_in on its own loads the word at addr_in onto data_out one clock later. data_out then holds that value until the next read.
- R3: If wr_in and rd_in are high in the same load-mode cycle, the write takes effect, no read is performed, and data_out keeps its previous value.
- R4: A rising run_in starts a sort. When the sort finishes, the words at addresses 0 to K-1 are in ascending order, compared as unsigned values (so 0x80 sorts above 0x7F).
- R5: Sorting preserves the multiset of stored words. Words of equal value are never exchanged, and duplicates all stay in the memory.
- R6: done_out rises once the sort is complete and stays high while run_in stays high.
- R7: When run_in is low while done_out is high, done_out is 0 one clock later. The block is then back in load mode, and a further sort can be started.
- R8: wr_in has no effect from the start of a sort until done_out rises.
- R9: The outer index stays at or below K-2, and the inner index stays above the outer one. Each exchange writes the outer position first and the inner position in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| run_in | input | 1 | 0 selects load mode; 1 requests or holds a sort |
| wr_in | input | 1 | Host write strobe (load mode only) |
| rd_in | input | 1 | Host read strobe |
| addr_in | input | AW | Host word address |
| data_in | input | WBITS | Host write data |
| data_out | output | WBITS | Registered memory read data |
| done_out | output | 1 | Sort finished; held while run_in is high |

## Verification
The memory has one port, so a host write and a host read can fall in the same load-mode cycle. The bench raises both strobes together on one address. It expects data_out to keep the word from the earlier read, and a later plain read of that address to return the new word. A host write that lands while a sort is running also competes with the controller for the port. The bench pulses wr_in during a sort and judges the case by reading back the sorted memory: it must match the original contents sorted, with no trace of the stray value.

// File: rtl/xsort_pkg.sv
package xsort_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RD_A,
    ST_CAP_A,
    ST_CAP_B,
    ST_CMP,
    ST_WR_I,
    ST_WR_J,
    ST_RELOAD,
    ST_RECAP,
    ST_NEXT,
    ST_RD_B,
    ST_DONE
  } sort_state_t;
endpackage

// File: rtl/xsort_ram.sv
module xsort_ram #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 8,
  parameter int AW    = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic             re,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic             in_range;

  assign in_range = (32'(addr) < DEPTH);

  always_ff @(posedge clk) begin
    if (we && in_range) mem[addr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)          rdata <= '0;
    else if (re)      rdata <= in_range ? mem[addr] : '0;
  end
endmodule

// File: rtl/xsort_datapath.sv
module xsort_datapath #(
  parameter int K  = 4,
  parameter int W  = 8,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_wr_ok,
  input  logic          host_rd_ok,
  input  logic          wr_in,
  input  logic          rd_in,
  input  logic [AW-1:0] addr_in,
  input  logic [W-1:0]  data_in,
  input  logic          i_clr,
  input  logic          i_inc,
  input  logic          j_ld,
  input  logic          j_inc,
  input  logic          a_ld,
  input  logic          b_ld,
  input  logic          sel_j,
  input  logic          wsel_a,
  input  logic          ctl_we,
  input  logic          ctl_re,
  input  logic [W-1:0]  rdata,
  output logic [AW-1:0] mem_addr,
  output logic [W-1:0]  mem_wdata,
  output logic          mem_we,
  output logic          mem_re,
  output logic          a_gt_b,
  output logic          i_last,
  output logic          j_last,
  output logic [AW-1:0] i_idx,
  output logic [AW-1:0] j_idx
);
  localparam logic [AW-1:0] I_END = AW'(K - 2);
  localparam logic [AW-1:0] J_END = AW'(K - 1);

  logic [W-1:0] a_q, b_q;
  logic         host_wr, host_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      i_idx <= '0;
      j_idx <= '0;
      a_q   <= '0;
      b_q   <= '0;
    end else begin
      if (i_clr)      i_idx <= '0;
      else if (i_inc) i_idx <= i_idx + 1'b1;
      if (j_ld)       j_idx <= i_idx + 1'b1;
      else if (j_inc) j_idx <= j_idx + 1'b1;
      if (a_ld)       a_q <= rdata;
      if (b_ld)       b_q <= rdata;
    end
  end

  assign a_gt_b = (a_q > b_q);
  assign i_last = (i_idx == I_END);
  assign j_last = (j_idx == J_END);

  assign host_wr = host_wr_ok & wr_in;
  assign host_rd = host_rd_ok & rd_in & ~host_wr;

  always_comb begin
    if (ctl_we || ctl_re) mem_addr = sel_j ? j_idx : i_idx;
    else                  mem_addr = addr_in;
    if (ctl_we)           mem_wdata = wsel_a ? a_q : b_q;
    else                  mem_wdata = data_in;
  end

  assign mem_we = ctl_we | host_wr;
  assign mem_re = ctl_re | host_rd;

  AST_PORT_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> !mem_re); // R3
  AST_HOST_LOCKOUT: assert property (@(posedge clk) disable iff (rst)
    (!host_wr_ok && wr_in && mem_we) |-> ctl_we); // R8
endmodule

// File: rtl/xsort_ctrl.sv
module xsort_ctrl #(
  parameter int K  = 4,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run_in,
  input  logic          a_gt_b,
  input  logic          i_last,
  input  logic          j_last,
  input  logic [AW-1:0] i_idx,
  input  logic [AW-1:0] j_idx,
  output logic          host_wr_ok,
  output logic          host_rd_ok,
  output logic          i_clr,
  output logic          i_inc,
  output logic          j_ld,
  output logic          j_inc,
  output logic          a_ld,
  output logic          b_ld,
  output logic          sel_j,
  output logic          wsel_a,
  output logic          ctl_we,
  output logic          ctl_re,
  output logic          done_out
);
  import xsort_pkg::*;

  sort_state_t state, nxt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      done_out <= 1'b0;
    end else begin
      state    <= nxt;
      done_out <= (nxt == ST_DONE);
    end
  end

  always_comb begin
    nxt    = state;
    i_clr  = 1'b0;
    i_inc  = 1'b0;
    j_ld   = 1'b0;
    j_inc  = 1'b0;
    a_ld   = 1'b0;
    b_ld   = 1'b0;
    sel_j  = 1'b0;
    wsel_a = 1'b0;
    ctl_we = 1'b0;
    ctl_re = 1'b0;
    unique case (state)
      ST_IDLE: if (run_in) begin
        i_clr = 1'b1;
        nxt   = ST_RD_A;
      end
      ST_RD_A: begin
        ctl_re = 1'b1;
        j_ld   = 1'b1;
        nxt    = ST_CAP_A;
      end
      ST_CAP_A: begin
        a_ld   = 1'b1;
        ctl_re = 1'b1;
        sel_j  = 1'b1;
        nxt    = ST_CAP_B;
      end
      ST_CAP_B: begin
        b_ld = 1'b1;
        nxt  = ST_CMP;
      end
      ST_CMP: nxt = a_gt_b ? ST_WR_I : ST_NEXT;
      ST_WR_I: begin
        ctl_we = 1'b1;
        nxt    = ST_WR_J;
      end
      ST_WR_J: begin
        ctl_we = 1'b1;
        sel_j  = 1'b1;
        wsel_a = 1'b1;
        nxt    = ST_RELOAD;
      end
      ST_RELOAD: begin
        ctl_re = 1'b1;
        nxt    = ST_RECAP;
      end
      ST_RECAP: begin
        a_ld = 1'b1;
        nxt  = ST_NEXT;
      end
      ST_NEXT: begin
        if (j_last) begin
          if (i_last) nxt = ST_DONE;
          else begin
            i_inc = 1'b1;
            nxt   = ST_RD_A;
          end
        end else begin
          j_inc = 1'b1;
          nxt   = ST_RD_B;
        end
      end
      ST_RD_B: begin
        ctl_re = 1'b1;
        sel_j  = 1'b1;
        nxt    = ST_CAP_B;
      end
      ST_DONE: if (!run_in) nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  assign host_wr_ok = (state == ST_IDLE);
  assign host_rd_ok = (state == ST_IDLE) || (state == ST_DONE);

  logic in_pass;
  assign in_pass = !(state inside {ST_IDLE, ST_RD_A, ST_DONE});

  AST_I_LIMIT: assert property (@(posedge clk) disable iff (rst)
    in_pass |-> (32'(i_idx) <= K - 2)); // R9
  AST_J_ABOVE_I: assert property (@(posedge clk) disable iff (rst)
    in_pass |-> (j_idx > i_idx)); // R9
  AST_SWAP_ORDER: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WR_J) |-> ($past(state) == ST_WR_I)); // R9
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (done_out && run_in) |=> done_out); // R6
  AST_DONE_DROP: assert property (@(posedge clk) disable iff (rst)
    (done_out && !run_in) |=> !done_out); // R7
endmodule

// File: rtl/xsort_engine.sv
module xsort_engine #(
  parameter int KWORDS = 4,
  parameter int WBITS  = 8,
  parameter int AW     = (KWORDS > 2) ? $clog2(KWORDS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_in,
  input  logic             wr_in,
  input  logic             rd_in,
  input  logic [AW-1:0]    addr_in,
  input  logic [WBITS-1:0] data_in,
  output logic [WBITS-1:0] data_out,
  output logic             done_out
);
  logic          host_wr_ok, host_rd_ok;
  logic          i_clr, i_inc, j_ld, j_inc, a_ld, b_ld;
  logic          sel_j, wsel_a, ctl_we, ctl_re;
  logic          a_gt_b, i_last, j_last;
  logic [AW-1:0] i_idx, j_idx, mem_addr;
  logic [WBITS-1:0] mem_wdata;
  logic          mem_we, mem_re;

  xsort_ctrl #(.K(KWORDS), .AW(AW)) ctrl_i (
    .clk(clk), .rst(rst), .run_in(run_in),
    .a_gt_b(a_gt_b), .i_last(i_last), .j_last(j_last),
    .i_idx(i_idx), .j_idx(j_idx),
    .host_wr_ok(host_wr_ok), .host_rd_ok(host_rd_ok),
    .i_clr(i_clr), .i_inc(i_inc), .j_ld(j_ld), .j_inc(j_inc),
    .a_ld(a_ld), .b_ld(b_ld), .sel_j(sel_j), .wsel_a(wsel_a),
    .ctl_we(ctl_we), .ctl_re(ctl_re), .done_out(done_out)
  );

  xsort_datapath #(.K(KWORDS), .W(WBITS), .AW(AW)) dp_i (
    .clk(clk), .rst(rst),
    .host_wr_ok(host_wr_ok), .host_rd_ok(host_rd_ok),
    .wr_in(wr_in), .rd_in(rd_in), .addr_in(addr_in), .data_in(data_in),
    .i_clr(i_clr), .i_inc(i_inc), .j_ld(j_ld), .j_inc(j_inc),
    .a_ld(a_ld), .b_ld(b_ld), .sel_j(sel_j), .wsel_a(wsel_a),
    .ctl_we(ctl_we), .ctl_re(ctl_re), .rdata(data_out),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_re(mem_re),
    .a_gt_b(a_gt_b), .i_last(i_last), .j_last(j_last),
    .i_idx(i_idx), .j_idx(j_idx)
  );

  xsort_ram #(.DEPTH(KWORDS), .WIDTH(WBITS), .AW(AW)) ram_i (
    .clk(clk), .rst(rst), .we(mem_we), .re(mem_re),
    .addr(mem_addr), .wdata(mem_wdata), .rdata(data_out)
  );

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    (host_wr_ok && !run_in && !rd_in) |=> $stable(data_out)); // R2
endmodule

// File: tb/xsort_engine_tb.sv
module xsort_engine_tb_top;
  localparam int K = 4;
  localparam int W = 8;
  localparam int AW = 2;

  logic clk = 1'b0, rst = 1'b1, run_in = 1'b0, wr_in = 1'b0, rd_in = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic [W-1:0]  data_in = '0;
  logic [W-1:0]  data_out;
  logic          done_out;

  int checks = 0, fails = 0;
  logic [W-1:0] vals [K];
  logic [W-1:0] exp_s [K];

  xsort_engine #(.KWORDS(K), .WBITS(W), .AW(AW)) dut_i (
    .clk(clk), .rst(rst), .run_in(run_in), .wr_in(wr_in), .rd_in(rd_in),
    .addr_in(addr_in), .data_in(data_in), .data_out(data_out), .done_out(done_out)
  );

  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic host_write(input int a, input logic [W-1:0] d);
    @(negedge clk);
    wr_in = 1'b1; addr_in = AW'(a); data_in = d;
    @(negedge clk);
    wr_in = 1'b0;
  endtask

  task automatic host_read(input int a, output logic [W-1:0] d);
    @(negedge clk);
    rd_in = 1'b1; addr_in = AW'(a);
    @(negedge clk);
    rd_in = 1'b0;
    d = data_out;
  endtask

  task automatic compute_expected();
    for (int m = 0; m < K; m++) exp_s[m] = vals[m];
    for (int p = 1; p < K; p++)
      for (int q = p; q > 0 && exp_s[q-1] > exp_s[q]; q--) begin
        logic [W-1:0] t;
        t = exp_s[q]; exp_s[q] = exp_s[q-1]; exp_s[q-1] = t;
      end
  endtask

  task automatic do_sort(input bit intrude);
    int n;
    logic [W-1:0] rv;
    for (int m = 0; m < K; m++) host_write(m, vals[m]);
    compute_expected();
    @(negedge clk);
    run_in = 1'b1;
    @(negedge clk);
    if (intrude) begin
      wr_in = 1'b1; addr_in = '0; data_in = 8'h5A;
      @(negedge clk);
      wr_in = 1'b0;
    end
    n = 0;
    while (!done_out && n < 2000) begin
      @(negedge clk);
      n++;
    end
    chk("R6 done rises", done_out, 1'b1);
    repeat (3) @(negedge clk);
    chk("R6 done held", done_out, 1'b1);
    run_in = 1'b0;
    @(negedge clk);
    chk("R7 done falls", done_out, 1'b0);
    for (int m = 0; m < K; m++) begin
      host_read(m, rv);
      chk(intrude ? "R8 write ignored" : "R4 R5 sorted word", rv, exp_s[m]);
    end
  endtask

  initial begin
    logic [W-1:0] rv;
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    chk("R1 data_out reset", data_out, '0);
    chk("R1 done reset", done_out, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 done after reset", done_out, 1'b0);

    host_write(1, 8'h3C);
    host_read(1, rv);
    chk("R2 readback", rv, 8'h3C);
    repeat (2) @(negedge clk);
    chk("R2 data held", data_out, 8'h3C);
    @(negedge clk);
    wr_in = 1'b1; rd_in = 1'b1; addr_in = 2'd2; data_in = 8'hC3;
    @(negedge clk);
    wr_in = 1'b0; rd_in = 1'b0;
    chk("R3 read skipped", data_out, 8'h3C);
    host_read(2, rv);
    chk("R3 write taken", rv, 8'hC3);

    for (int set = 0; set < 2; set++)
      for (int p = 0; p < 24; p++) begin
        int pool [4];
        int r, f;
        if (set == 0) begin pool = '{10, 20, 30, 40}; end
        else          begin pool = '{8'h00, 8'h7F, 8'h80, 8'hFF}; end
        r = p;
        for (int m = 0; m < K; m++) begin
          f = 1;
          for (int z = 1; z < K - m; z++) f *= z;
          vals[m] = W'(pool[r / f]);
          for (int z = r / f; z < K - 1 - m; z++) pool[z] = pool[z+1];
          r = r % f;
        end
        do_sort(1'b0);
      end

    vals = '{8'h07, 8'h07, 8'h07, 8'h07}; do_sort(1'b0);
    vals = '{8'h09, 8'h02, 8'h09, 8'h02}; do_sort(1'b0);
    vals = '{8'hFF, 8'h00, 8'hFF, 8'h01}; do_sort(1'b0);
    lfsr = 16'hACE1;
    for (int t = 0; t < 40; t++) begin
      for (int m = 0; m < K; m++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        vals[m] = (t % 2 == 0) ? lfsr[7:0] : {6'd0, lfsr[1:0]};
      end
      do_sort(1'b0);
    end

    vals = '{8'h44, 8'h11, 8'h33, 8'h22}; do_sort(1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule